// File: doc/BRIEF.md
# Branch Squash Arbiter

This block collects branch-resolution reports from several pipeline stages in the same clock. Each report carries a thread number, the branch sequence number, its PC values, the predicted target and the sequence number of the delay-slot instruction that follows the branch. For each thread the block keeps only the oldest branch reported in the cycle and drops the rest, because squashing from the oldest branch already removes every younger one. For the winner it broadcasts a misprediction squash on the next clock. The broadcast gives the branch sequence number, the squash point, the redirect PC (the predicted target) and a taken flag. It also keeps, for each thread, the squash point and the cycle number in which that squash was decided.

While a squash is being decided, the same cycle's forwarding lanes ask whether an instruction they are about to push into the next stage queue should be discarded. A lane is told to drop its instruction when it belongs to a thread with a squash this cycle and is younger than that squash point. The drop signal is combinational and exists only in the squash cycle. A build parameter chooses between a pipeline without delay slots (the squash point is the branch itself) and one with delay slots (the squash point is the delay-slot instruction). That parameter also picks how the taken flag is computed.

Top module: `branch_squash_arbiter`

## Requirements
- R1: While rst_n is low at a clock edge, all squash outputs, the stored squash points, the stored cycles and the cycle counter are cleared to zero.
- R2: A valid report that wins for its thread raises sq_valid for that thread on the following clock, with sq_seq equal to the branch sequence number, sq_next_pc equal to the predicted target and sq_src equal to the index of the reporting source.
- R3: When several sources report for one thread in the same cycle, the report with the smallest sequence number (unsigned, no wraparound) is the only one broadcast; the younger reports are ignored.
- R4: When reports for one thread carry equal sequence numbers, the lowest source index wins.
- R5: Reports for different threads in the same cycle are arbitrated separately, and each thread gets its own broadcast.
- R6: With DELAY_SLOT = 0, sq_taken is 1 exactly when the branch's next PC differs from its PC plus INST_BYTES, and sq_point equals the branch sequence number.
- R7: With DELAY_SLOT = 1, sq_taken is 1 exactly when the next-next PC differs from the next PC plus INST_BYTES, and sq_point equals the delay-slot sequence number.
- R8: On a broadcast, rec_point of that thread holds the squash point and rec_cycle holds the value cycle_now had in the cycle of the report; with no report for the thread, both keep their values.
- R9: cycle_now rises by one on every clock after reset, wrapping at 2^CYC_W.
- R10: In a cycle with a winning report for thread t, forwarding lane l asserts fwd_drop[l] exactly when the lane is valid, names thread t and carries a sequence number strictly greater than the squash point; other threads and older or equal sequence numbers are not dropped.
- R11: In a cycle without a report for a thread, no lane of that thread is dropped, whatever the stored squash point.
- R12: A squash stored in an earlier cycle does not suppress a later report, even one younger than the stored point.
- R13: sq_valid is a single-cycle pulse: it is low on the clock after a cycle with no report for that thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | NUM_SRC | One report strobe per source |
| ev_tid | input | NUM_SRC*TID_W | Thread of each report |
| ev_seq | input | NUM_SRC*32 | Branch sequence number per source |
| ev_pc | input | NUM_SRC*PC_W | Branch PC per source |
| ev_npc | input | NUM_SRC*PC_W | Resolved next PC per source |
| ev_nnpc | input | NUM_SRC*PC_W | Resolved next-next PC per source (delay-slot builds) |
| ev_target | input | NUM_SRC*PC_W | Predicted target, used as redirect PC |
| ev_slot_seq | input | NUM_SRC*32 | Delay-slot sequence number per source |
| fwd_valid | input | LANES | Forwarding lane strobe |
| fwd_tid | input | LANES*TID_W | Thread of the forwarded instruction |
| fwd_seq | input | LANES*32 | Sequence number of the forwarded instruction |
| fwd_drop | output | LANES | Discard the forwarded instruction this cycle |
| sq_valid | output | NUM_THR | Squash and mispredict broadcast per thread |
| sq_seq | output | NUM_THR*32 | Sequence number of the squashing branch |
| sq_point | output | NUM_THR*32 | Squash point: younger instructions are flushed |
| sq_next_pc | output | NUM_THR*PC_W | Redirect PC |
| sq_taken | output | NUM_THR | Branch-taken flag |
| sq_src | output | NUM_THR*SRC_W | Source index of the winning report |
| rec_point | output | NUM_THR*32 | Stored squash point per thread |
| rec_cycle | output | NUM_THR*CYC_W | Cycle number of the stored squash |
| cycle_now | output | CYC_W | Free-running cycle counter |

## Verification
The arbitration that picks the oldest report and the forwarding filter act in the same cycle, and the filter must compare against the winner's squash point rather than any losing report. The bench drives reports from several sources for one thread together with forwarding lanes whose sequence numbers lie just above, at and below the winning point. It then checks the combinational drop before the clock edge and the registered broadcast after it. The following idle cycle is checked to confirm the filter releases while the stored point remains, and both delay-slot builds run side by side on the same stimulus so their different squash points give different drop results.

// File: rtl/sqarb_pkg.sv
// Package sqarb_pkg
// Shared constants for the branch squash arbiter.
// Assumes sequence numbers are 32-bit unsigned and never wrap within
// the lifetime of an in-flight branch.
package sqarb_pkg;
    localparam int SEQ_W = 32;
    typedef logic [SEQ_W-1:0] seq_t;
endpackage

// File: rtl/sqarb_resolve.sv
// Module sqarb_resolve
// Per-source resolution: derives the taken flag and the squash point of
// one branch report. DELAY_SLOT selects the variant: without delay slots
// the branch itself is the squash point and taken compares next PC with
// PC + INST_BYTES; with delay slots the delay-slot instruction is the
// squash point and taken compares next-next PC with next PC + INST_BYTES.
// Assumes PC values are byte addresses of width PC_W.
module sqarb_resolve
    import sqarb_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int INST_BYTES = 4,
    parameter bit DELAY_SLOT = 1'b0
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] npc,
    input  logic [PC_W-1:0] nnpc,
    input  seq_t            seq,
    input  seq_t            slot_seq,
    output logic            taken,
    output seq_t            point
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

    generate
        if (DELAY_SLOT) begin : g_slot
            logic unused_inputs;
            // Delay-slot variant: redirect happens after the slot instruction.
            assign taken         = (nnpc != (npc + STEP));
            assign point         = slot_seq;
            assign unused_inputs = ^{pc, seq};
        end else begin : g_plain
            logic unused_inputs;
            // Plain variant: redirect right after the branch.
            assign taken         = (npc != (pc + STEP));
            assign point         = seq;
            assign unused_inputs = ^{nnpc, slot_seq};
        end
    endgenerate
endmodule

// File: rtl/sqarb_pick.sv
// Module sqarb_pick
// Oldest-first selection among the candidate reports of one thread.
// Picks the smallest sequence number; on equal numbers the lowest source
// index wins, matching a scan from the nearest stage outward.
// Assumes cand is already qualified by valid and thread match.
module sqarb_pick
    import sqarb_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int SRC_W   = 2
) (
    input  logic [NUM_SRC-1:0]       cand,
    input  logic [NUM_SRC*SEQ_W-1:0] seq_flat,
    output logic                     win_valid,
    output logic [SRC_W-1:0]         win_idx
);
    // Linear scan keeping the oldest candidate seen so far.
    always_comb begin
        logic found;
        seq_t best;
        logic [SRC_W-1:0] idx;
        found = 1'b0;
        best  = '0;
        idx   = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (cand[s] && (!found || (seq_flat[s*SEQ_W +: SEQ_W] < best))) begin
                found = 1'b1;
                best  = seq_flat[s*SEQ_W +: SEQ_W];
                idx   = SRC_W'(s);
            end
        end
        win_valid = found;
        win_idx   = idx;
    end
endmodule

// File: rtl/sqarb_filter.sv
// Module sqarb_filter
// Same-cycle forwarding filter: tells each forwarding lane to discard an
// instruction that is younger than a squash point decided in this cycle
// for the same thread. Purely combinational; it sees only the current
// cycle's winners, so it releases as soon as the squash cycle is over.
// Assumes lane thread numbers outside NUM_THR are never dropped.
module sqarb_filter
    import sqarb_pkg::*;
#(
    parameter int NUM_THR = 2,
    parameter int LANES   = 2,
    parameter int TID_W   = 1
) (
    input  logic [NUM_THR-1:0]       win_valid,
    input  logic [NUM_THR*SEQ_W-1:0] win_point,
    input  logic [LANES-1:0]         fwd_valid,
    input  logic [LANES*TID_W-1:0]   fwd_tid,
    input  logic [LANES*SEQ_W-1:0]   fwd_seq,
    output logic [LANES-1:0]         fwd_drop
);
    // Compare every lane against the squash point of its own thread.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            logic [TID_W-1:0] tid;
            tid         = fwd_tid[l*TID_W +: TID_W];
            fwd_drop[l] = 1'b0;
            for (int t = 0; t < NUM_THR; t++) begin
                if (fwd_valid[l] && (tid == TID_W'(t)) && win_valid[t] &&
                    (fwd_seq[l*SEQ_W +: SEQ_W] > win_point[t*SEQ_W +: SEQ_W])) begin
                    fwd_drop[l] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/branch_squash_arbiter.sv
// Module branch_squash_arbiter
// Collects branch-resolution reports from NUM_SRC stages, keeps the oldest
// per thread each cycle, broadcasts its squash one clock later and stores
// the squash point with the cycle number it was decided in. A forwarding
// filter flags younger instructions of a squashing thread in the same cycle.
// Assumes: synchronous active-low reset; at most one report per source per
// cycle; slot sequence number is not older than its branch.
module branch_squash_arbiter
    import sqarb_pkg::*;
#(
    parameter int NUM_SRC    = 3,
    parameter int NUM_THR    = 2,
    parameter int PC_W       = 32,
    parameter int LANES      = 2,
    parameter int CYC_W      = 16,
    parameter int INST_BYTES = 4,
    parameter bit DELAY_SLOT = 1'b0,
    parameter int TID_W      = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
    parameter int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         ev_valid,
    input  logic [NUM_SRC*TID_W-1:0]   ev_tid,
    input  logic [NUM_SRC*SEQ_W-1:0]   ev_seq,
    input  logic [NUM_SRC*PC_W-1:0]    ev_pc,
    input  logic [NUM_SRC*PC_W-1:0]    ev_npc,
    input  logic [NUM_SRC*PC_W-1:0]    ev_nnpc,
    input  logic [NUM_SRC*PC_W-1:0]    ev_target,
    input  logic [NUM_SRC*SEQ_W-1:0]   ev_slot_seq,
    input  logic [LANES-1:0]           fwd_valid,
    input  logic [LANES*TID_W-1:0]     fwd_tid,
    input  logic [LANES*SEQ_W-1:0]     fwd_seq,
    output logic [LANES-1:0]           fwd_drop,
    output logic [NUM_THR-1:0]         sq_valid,
    output logic [NUM_THR*SEQ_W-1:0]   sq_seq,
    output logic [NUM_THR*SEQ_W-1:0]   sq_point,
    output logic [NUM_THR*PC_W-1:0]    sq_next_pc,
    output logic [NUM_THR-1:0]         sq_taken,
    output logic [NUM_THR*SRC_W-1:0]   sq_src,
    output logic [NUM_THR*SEQ_W-1:0]   rec_point,
    output logic [NUM_THR*CYC_W-1:0]   rec_cycle,
    output logic [CYC_W-1:0]           cycle_now
);
    // Per-source resolution results.
    logic [NUM_SRC-1:0]       src_taken;
    logic [NUM_SRC*SEQ_W-1:0] src_point;

    // Per-thread winners of the current cycle.
    logic [NUM_THR-1:0]       win_valid;
    logic [NUM_THR*SEQ_W-1:0] win_point;
    logic [NUM_THR*SEQ_W-1:0] win_seq;
    logic [NUM_THR*PC_W-1:0]  win_pc;
    logic [NUM_THR-1:0]       win_taken;
    logic [NUM_THR*SRC_W-1:0] win_src;

    logic [CYC_W-1:0] cycle_q;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            sqarb_resolve #(
                .PC_W       (PC_W),
                .INST_BYTES (INST_BYTES),
                .DELAY_SLOT (DELAY_SLOT)
            ) u_resolve (
                .pc       (ev_pc[s*PC_W +: PC_W]),
                .npc      (ev_npc[s*PC_W +: PC_W]),
                .nnpc     (ev_nnpc[s*PC_W +: PC_W]),
                .seq      (ev_seq[s*SEQ_W +: SEQ_W]),
                .slot_seq (ev_slot_seq[s*SEQ_W +: SEQ_W]),
                .taken    (src_taken[s]),
                .point    (src_point[s*SEQ_W +: SEQ_W])
            );
        end

        for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
            logic [NUM_SRC-1:0] cand;
            logic [SRC_W-1:0]   idx;

            // Qualify each source report by validity and thread match.
            always_comb begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    cand[s] = ev_valid[s] && (ev_tid[s*TID_W +: TID_W] == TID_W'(t));
                end
            end

            sqarb_pick #(
                .NUM_SRC (NUM_SRC),
                .SRC_W   (SRC_W)
            ) u_pick (
                .cand      (cand),
                .seq_flat  (ev_seq),
                .win_valid (win_valid[t]),
                .win_idx   (idx)
            );

            // Route the winning source's fields to this thread.
            always_comb begin
                win_point[t*SEQ_W +: SEQ_W] = src_point[idx*SEQ_W +: SEQ_W];
                win_seq[t*SEQ_W +: SEQ_W]   = ev_seq[idx*SEQ_W +: SEQ_W];
                win_pc[t*PC_W +: PC_W]      = ev_target[idx*PC_W +: PC_W];
                win_taken[t]                = src_taken[idx];
                win_src[t*SRC_W +: SRC_W]   = idx;
            end

            // Broadcast register: one-cycle squash pulse with its payload.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sq_valid[t]                  <= 1'b0;
                    sq_seq[t*SEQ_W +: SEQ_W]     <= '0;
                    sq_point[t*SEQ_W +: SEQ_W]   <= '0;
                    sq_next_pc[t*PC_W +: PC_W]   <= '0;
                    sq_taken[t]                  <= 1'b0;
                    sq_src[t*SRC_W +: SRC_W]     <= '0;
                end else begin
                    sq_valid[t] <= win_valid[t];
                    if (win_valid[t]) begin
                        sq_seq[t*SEQ_W +: SEQ_W]   <= win_seq[t*SEQ_W +: SEQ_W];
                        sq_point[t*SEQ_W +: SEQ_W] <= win_point[t*SEQ_W +: SEQ_W];
                        sq_next_pc[t*PC_W +: PC_W] <= win_pc[t*PC_W +: PC_W];
                        sq_taken[t]                <= win_taken[t];
                        sq_src[t*SRC_W +: SRC_W]   <= win_src[t*SRC_W +: SRC_W];
                    end
                end
            end

            // Record register: squash point and the cycle it was decided in.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rec_point[t*SEQ_W +: SEQ_W] <= '0;
                    rec_cycle[t*CYC_W +: CYC_W] <= '0;
                end else if (win_valid[t]) begin
                    rec_point[t*SEQ_W +: SEQ_W] <= win_point[t*SEQ_W +: SEQ_W];
                    rec_cycle[t*CYC_W +: CYC_W] <= cycle_q;
                end
            end
        end
    endgenerate

    // Free-running cycle counter used to tag stored squashes.
    always_ff @(posedge clk) begin
        if (!rst_n) cycle_q <= '0;
        else        cycle_q <= cycle_q + 1'b1;
    end
    assign cycle_now = cycle_q;

    sqarb_filter #(
        .NUM_THR (NUM_THR),
        .LANES   (LANES),
        .TID_W   (TID_W)
    ) u_filter (
        .win_valid (win_valid),
        .win_point (win_point),
        .fwd_valid (fwd_valid),
        .fwd_tid   (fwd_tid),
        .fwd_seq   (fwd_seq),
        .fwd_drop  (fwd_drop)
    );
endmodule

// File: rtl/sqarb_checker.sv
// Module sqarb_checker
// Temporal checks on the arbiter's ports, bound to every instance.
// Assumes the same parameters as the bound arbiter.
module sqarb_checker
    import sqarb_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int NUM_THR = 2,
    parameter int LANES   = 2,
    parameter int CYC_W   = 16,
    parameter int TID_W   = 1,
    parameter int SRC_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       ev_valid,
    input logic [NUM_SRC*TID_W-1:0] ev_tid,
    input logic [LANES-1:0]         fwd_valid,
    input logic [LANES*TID_W-1:0]   fwd_tid,
    input logic [LANES-1:0]         fwd_drop,
    input logic [NUM_THR-1:0]       sq_valid,
    input logic [NUM_THR*SRC_W-1:0] sq_src,
    input logic [NUM_THR*SEQ_W-1:0] rec_point,
    input logic [NUM_THR*CYC_W-1:0] rec_cycle,
    input logic [CYC_W-1:0]         cycle_now
);
    logic [NUM_THR-1:0] thr_ev;

    // Whether any source reports for each thread this cycle.
    always_comb begin
        thr_ev = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int t = 0; t < NUM_THR; t++) begin
                if (ev_valid[s] && (ev_tid[s*TID_W +: TID_W] == TID_W'(t))) thr_ev[t] = 1'b1;
            end
        end
    end

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cycle_now == $past(cycle_now) + 1'b1); // R9

    generate
        for (genvar t = 0; t < NUM_THR; t++) begin : g_t
            AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
                !thr_ev[t] |=> !sq_valid[t]); // R13
            AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !thr_ev[t] |=> $stable(rec_point[t*SEQ_W +: SEQ_W])); // R8
            AST_REC_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                sq_valid[t] |-> rec_cycle[t*CYC_W +: CYC_W] == CYC_W'(cycle_now - 1'b1)); // R8
            AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                sq_valid[t] |-> int'(sq_src[t*SRC_W +: SRC_W]) < NUM_SRC); // R3
        end
        for (genvar l = 0; l < LANES; l++) begin : g_l
            AST_DROP_NEEDS_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
                fwd_drop[l] |-> fwd_valid[l] && thr_ev[fwd_tid[l*TID_W +: TID_W]]); // R10
        end
    endgenerate
endmodule

bind branch_squash_arbiter sqarb_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_THR (NUM_THR),
    .LANES   (LANES),
    .CYC_W   (CYC_W),
    .TID_W   (TID_W),
    .SRC_W   (SRC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_tid    (ev_tid),
    .fwd_valid (fwd_valid),
    .fwd_tid   (fwd_tid),
    .fwd_drop  (fwd_drop),
    .sq_valid  (sq_valid),
    .sq_src    (sq_src),
    .rec_point (rec_point),
    .rec_cycle (rec_cycle),
    .cycle_now (cycle_now)
);

// File: tb/branch_squash_arbiter_test.sv
// Directed bench: a plain build (uut) and a delay-slot build (uut_ds)
// share all inputs. Inputs change at the falling edge; registered outputs
// are read at the next falling edge, combinational drops before the rise.
module branch_squash_arbiter_test;
    localparam int CLK_P = 10;
    localparam int NS = 3, NT = 2, NL = 2, CW = 16, SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    ev_valid;
    logic [NS-1:0]    ev_tid;
    logic [NS*32-1:0] ev_seq, ev_pc, ev_npc, ev_nnpc, ev_target, ev_slot;
    logic [NL-1:0]    fwd_valid;
    logic [NL-1:0]    fwd_tid;
    logic [NL*32-1:0] fwd_seq;

    logic [NL-1:0]    a_drop, b_drop;
    logic [NT-1:0]    a_sqv, b_sqv, a_tk, b_tk;
    logic [NT*32-1:0] a_seq, b_seq, a_pt, b_pt, a_npc, b_npc, a_rpt, b_rpt;
    logic [NT*SW-1:0] a_src, b_src;
    logic [NT*CW-1:0] a_rcy, b_rcy;
    logic [CW-1:0]    a_cyc, b_cyc;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    branch_squash_arbiter #(.NUM_SRC(NS), .NUM_THR(NT), .LANES(NL), .CYC_W(CW), .DELAY_SLOT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_tid(ev_tid), .ev_seq(ev_seq),
        .ev_pc(ev_pc), .ev_npc(ev_npc), .ev_nnpc(ev_nnpc), .ev_target(ev_target),
        .ev_slot_seq(ev_slot), .fwd_valid(fwd_valid), .fwd_tid(fwd_tid), .fwd_seq(fwd_seq),
        .fwd_drop(a_drop), .sq_valid(a_sqv), .sq_seq(a_seq), .sq_point(a_pt),
        .sq_next_pc(a_npc), .sq_taken(a_tk), .sq_src(a_src), .rec_point(a_rpt),
        .rec_cycle(a_rcy), .cycle_now(a_cyc));

    branch_squash_arbiter #(.NUM_SRC(NS), .NUM_THR(NT), .LANES(NL), .CYC_W(CW), .DELAY_SLOT(1'b1)) uut_ds (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_tid(ev_tid), .ev_seq(ev_seq),
        .ev_pc(ev_pc), .ev_npc(ev_npc), .ev_nnpc(ev_nnpc), .ev_target(ev_target),
        .ev_slot_seq(ev_slot), .fwd_valid(fwd_valid), .fwd_tid(fwd_tid), .fwd_seq(fwd_seq),
        .fwd_drop(b_drop), .sq_valid(b_sqv), .sq_seq(b_seq), .sq_point(b_pt),
        .sq_next_pc(b_npc), .sq_taken(b_tk), .sq_src(b_src), .rec_point(b_rpt),
        .rec_cycle(b_rcy), .cycle_now(b_cyc));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        ev_valid = '0; ev_tid = '0; ev_seq = '0; ev_pc = '0; ev_npc = '0;
        ev_nnpc = '0; ev_target = '0; ev_slot = '0;
        fwd_valid = '0; fwd_tid = '0; fwd_seq = '0;
    endtask

    task automatic put_ev(input int s, input int tid, input logic [31:0] seq, input logic [31:0] pc,
                          input logic [31:0] npc, input logic [31:0] nnpc, input logic [31:0] tgt,
                          input logic [31:0] slot);
        ev_valid[s] = 1'b1;
        ev_tid[s] = tid[0];
        ev_seq[s*32 +: 32] = seq;
        ev_pc[s*32 +: 32] = pc;
        ev_npc[s*32 +: 32] = npc;
        ev_nnpc[s*32 +: 32] = nnpc;
        ev_target[s*32 +: 32] = tgt;
        ev_slot[s*32 +: 32] = slot;
    endtask

    task automatic put_fwd(input int l, input int tid, input logic [31:0] seq);
        fwd_valid[l] = 1'b1;
        fwd_tid[l] = tid[0];
        fwd_seq[l*32 +: 32] = seq;
    endtask

    // Advance one clock and land on the next falling edge.
    task automatic step();
        @(posedge clk);
        #(CLK_P/2);
    endtask

    task automatic t_reset();
        chk("R1", "sq_valid", 32'(a_sqv), 0);
        chk("R1", "cycle_now", 32'(a_cyc), 0);
        chk("R1", "rec_point", a_rpt[31:0], 0);
        chk("R1", "rec_cycle", 32'(b_rcy), 0);
    endtask

    task automatic t_cycle();
        logic [CW-1:0] c0;
        c0 = a_cyc;
        step();
        chk("R9", "cycle step", 32'(a_cyc), 32'(c0 + 1'b1));
    endtask

    task automatic t_single();
        logic [CW-1:0] c0;
        clear_in();
        put_ev(1, 0, 100, 32'h1000, 32'h1004, 32'h2000, 32'h3000, 101);
        c0 = a_cyc;
        step();
        clear_in();
        chk("R2", "sq_valid t0", 32'(a_sqv[0]), 1);
        chk("R2", "sq_seq", a_seq[31:0], 100);
        chk("R2", "sq_next_pc", a_npc[31:0], 32'h3000);
        chk("R2", "sq_src", 32'(a_src[1:0]), 1);
        chk("R6", "taken plain", 32'(a_tk[0]), 0);
        chk("R6", "point plain", a_pt[31:0], 100);
        chk("R7", "taken slot", 32'(b_tk[0]), 1);
        chk("R7", "point slot", b_pt[31:0], 101);
        chk("R8", "rec_point plain", a_rpt[31:0], 100);
        chk("R8", "rec_point slot", b_rpt[31:0], 101);
        chk("R8", "rec_cycle", 32'(a_rcy[CW-1:0]), 32'(c0));
        chk("R5", "other thread idle", 32'(a_sqv[1]), 0);
        step();
        chk("R13", "pulse ends", 32'(a_sqv[0]), 0);
        chk("R8", "rec_point held", a_rpt[31:0], 100);
    endtask

    task automatic t_taken_flip();
        clear_in();
        put_ev(0, 1, 7, 32'h40, 32'h5000, 32'h5004, 32'h5000, 8);
        step();
        clear_in();
        chk("R6", "taken plain jump", 32'(a_tk[1]), 1);
        chk("R7", "taken slot fallthrough", 32'(b_tk[1]), 0);
        chk("R2", "sq_valid t1", 32'(a_sqv[1]), 1);
    endtask

    task automatic t_oldest();
        clear_in();
        put_ev(0, 0, 50, 0, 4, 8, 32'hA0, 51);
        put_ev(2, 0, 40, 0, 4, 8, 32'hB0, 41);
        step();
        clear_in();
        chk("R3", "winner seq", a_seq[31:0], 40);
        chk("R3", "winner src", 32'(a_src[1:0]), 2);
        chk("R3", "winner target", a_npc[31:0], 32'hB0);
    endtask

    task automatic t_tie();
        clear_in();
        put_ev(2, 1, 70, 0, 4, 8, 32'hC2, 71);
        put_ev(0, 1, 70, 0, 4, 8, 32'hC0, 71);
        step();
        clear_in();
        chk("R4", "tie src", 32'(a_src[3:2]), 0);
        chk("R4", "tie target", a_npc[63:32], 32'hC0);
    endtask

    task automatic t_threads();
        clear_in();
        put_ev(0, 0, 10, 0, 4, 8, 32'hD0, 11);
        put_ev(1, 1, 20, 0, 4, 8, 32'hD1, 21);
        step();
        clear_in();
        chk("R5", "t0 valid", 32'(a_sqv[0]), 1);
        chk("R5", "t1 valid", 32'(a_sqv[1]), 1);
        chk("R5", "t0 seq", a_seq[31:0], 10);
        chk("R5", "t1 seq", a_seq[63:32], 20);
    endtask

    task automatic t_filter();
        clear_in();
        put_ev(1, 0, 200, 0, 4, 8, 32'hE0, 201);
        put_ev(2, 0, 230, 0, 4, 8, 32'hE8, 231);
        put_fwd(0, 0, 201);
        put_fwd(1, 1, 500);
        #1;
        chk("R10", "younger dropped plain", 32'(a_drop[0]), 1);
        chk("R10", "slot not dropped slot", 32'(b_drop[0]), 0);
        chk("R10", "other thread kept", 32'(a_drop[1]), 0);
        fwd_seq[31:0] = 200;
        #1;
        chk("R10", "equal kept", 32'(a_drop[0]), 0);
        fwd_seq[31:0] = 215;
        #1;
        chk("R10", "point from winner", 32'(a_drop[0]), 1);
        step();
        clear_in();
        put_fwd(0, 0, 300);
        #1;
        chk("R11", "released after squash cycle", 32'(a_drop[0]), 0);
        chk("R11", "released slot build", 32'(b_drop[0]), 0);
        chk("R8", "record kept", a_rpt[31:0], 200);
        step();
        clear_in();
    endtask

    task automatic t_prior();
        clear_in();
        put_ev(0, 0, 30, 0, 4, 8, 32'hF0, 31);
        step();
        clear_in();
        step();
        put_ev(1, 0, 60, 0, 4, 8, 32'hF8, 61);
        step();
        clear_in();
        chk("R12", "later younger accepted", 32'(a_sqv[0]), 1);
        chk("R12", "later seq", a_seq[31:0], 60);
        chk("R12", "record moved", a_rpt[31:0], 60);
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_in();
        rst_n = 1'b0;
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        t_cycle();
        t_single();
        t_taken_flip();
        t_oldest();
        t_tie();
        t_threads();
        t_filter();
        t_prior();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule